// File: doc/BRIEF.md
# Floating-Point Sign-Inversion Unit

This unit decodes one coprocessor-1 instruction word and, when it names the negate operation, returns the source operand with its sign inverted. Three operand formats are supported: single (32 bits), double (64 bits) and paired-single, which is two singles packed into one 64-bit value and handled lane by lane. The register file, trap delivery and the status register are outside the unit. It reports only the conditions it detects: invalid operation, an undefined combination and an illegal encoding.

A mode input selects between two behaviours. In the arithmetic mode, a NaN operand raises the invalid-operation flag. In the sign-only mode, every value, NaN or not, only has its top bit inverted and never raises a flag. A register-model input states whether 64-bit registers are present. Paired-single results are only defined when they are. The unit has one registered stage, so each accepted input produces its outputs one clock later.

Top module: `fneg_unit`

## Requirements
- R1: An instruction is legal only when bits 31:26 are 010001, bits 20:16 are zero, bits 5:0 are 000111, and bits 25:21 hold 10000 (single), 10001 (double) or 10110 (paired-single). Any other word asserts `rsvd_instr` and keeps `wr_en` low.
- R2: A legal double operation inverts bit 63 of `src_val`. All other bits reach `result` unchanged.
- R3: A legal single operation inverts bit 31, passes bits 30:0 through unchanged, and drives `result[63:32]` to zero.
- R4: While `sign_only` is 1, `invalid_op` is never asserted, whatever the operand.
- R5: While `sign_only` is 0, an operand that is a NaN asserts `invalid_op`. A single NaN has bits 30:23 all ones and bits 22:0 non-zero. A double NaN has bits 62:52 all ones and bits 51:0 non-zero. The sign-inverted operand is still written, with `wr_en` high.
- R6: A paired-single operation inverts bits 63 and 31 independently. Its invalid condition is the OR of the single-format NaN tests on the two halves.
- R7: A legal paired-single operation with `reg64` at 0 asserts `unpredictable`, keeps `wr_en` and `invalid_op` low, and does not assert `rsvd_instr`.
- R8: `dst_idx` carries instruction bits 10:6 of the accepted word.
- R9: `out_valid` equals `in_valid` delayed by one clock. With no accepted input, `wr_en`, `invalid_op`, `rsvd_instr` and `unpredictable` are low.
- R10: A synchronous reset clears `out_valid`, `wr_en` and all three flags on the next edge, even when `in_valid` is high.
- R11: `result` is all zeros in every cycle where `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operand are present |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Value of the source register named by bits 15:11 |
| sign_only | input | 1 | 1: sign-only mode, 0: arithmetic mode |
| reg64 | input | 1 | 1: 64-bit register model, 0: 32-bit register model |
| out_valid | output | 1 | Outputs refer to the input of the previous cycle |
| result | output | 64 | Sign-inverted value |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write `result` to `dst_idx` |
| invalid_op | output | 1 | Invalid-operation condition detected |
| rsvd_instr | output | 1 | Illegal encoding |
| unpredictable | output | 1 | Paired-single issued under the 32-bit register model |

## Verification
The bench builds the unit with its default geometry: 8-bit and 11-bit exponents, format codes 10000, 10001 and 10110. With those defaults, all 32 values of the format field can be swept in both modes and both register models. Each combination is applied to operands chosen to place infinities, quiet and signalling NaNs and ordinary numbers in either half. This covers every format decode, the NaN boundary at a zero mantissa, the OR of the two lane flags, and the undefined paired-single case. Separate vectors with a corrupted opcode, function field or zero field, a reset during a valid input, and idle cycles cover the remaining rules.

// File: rtl/fneg_pkg.sv
package fneg_pkg;

   typedef enum logic [1:0] {
      K_SINGLE = 2'd0,
      K_DOUBLE = 2'd1,
      K_PAIRED = 2'd2,
      K_NONE   = 2'd3
   } fkind_e;

   localparam logic [5:0] OPC_COP1  = 6'b010001;
   localparam logic [5:0] FUNC_NEG  = 6'b000111;
   localparam logic [4:0] CODE_S    = 5'b10000;
   localparam logic [4:0] CODE_D    = 5'b10001;
   localparam logic [4:0] CODE_PS   = 5'b10110;

endpackage

// File: rtl/fneg_decode.sv
module fneg_decode
   import fneg_pkg::*;
#(
   parameter logic [4:0] FMT_S  = CODE_S,
   parameter logic [4:0] FMT_D  = CODE_D,
   parameter logic [4:0] FMT_PS = CODE_PS,
   parameter int         IDX_W  = 5
) (
   input  logic [31:0]      instr,
   output fkind_e           kind,
   output logic             legal,
   output logic [IDX_W-1:0] fd
);

   if (IDX_W != 5) begin : g_bad_idx
      $error("fneg_decode: register index must be 5 bits");
   end
   if (FMT_S == FMT_D || FMT_S == FMT_PS || FMT_D == FMT_PS) begin : g_bad_codes
      $error("fneg_decode: format codes must differ");
   end

   logic [5:0] opc, func;
   logic [4:0] fmt, zero_f;

   assign opc    = instr[31:26];
   assign fmt    = instr[25:21];
   assign zero_f = instr[20:16];
   assign fd     = instr[10:6];
   assign func   = instr[5:0];

   always_comb begin
      if (fmt == FMT_S)       kind = K_SINGLE;
      else if (fmt == FMT_D)  kind = K_DOUBLE;
      else if (fmt == FMT_PS) kind = K_PAIRED;
      else                    kind = K_NONE;
   end

   assign legal = (opc == OPC_COP1) && (func == FUNC_NEG) &&
                  (zero_f == 5'd0) && (kind != K_NONE);

endmodule

// File: rtl/fneg_lane.sv
module fneg_lane #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] op,
   output logic [EXP_W+MAN_W:0] neg,
   output logic                 is_nan
);

   localparam int W = EXP_W + MAN_W + 1;

   if (EXP_W < 2 || MAN_W < 1) begin : g_bad_geom
      $error("fneg_lane: exponent and mantissa too narrow");
   end

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;

   assign exp_f  = op[W-2:MAN_W];
   assign man_f  = op[MAN_W-1:0];
   assign is_nan = (&exp_f) && (|man_f);
   assign neg    = {~op[W-1], op[W-2:0]};

endmodule

// File: rtl/fneg_unit.sv
module fneg_unit
   import fneg_pkg::*;
#(
   parameter int         SP_EXP = 8,
   parameter int         SP_MAN = 23,
   parameter int         DP_EXP = 11,
   parameter int         DP_MAN = 52,
   parameter logic [4:0] FMT_S  = CODE_S,
   parameter logic [4:0] FMT_D  = CODE_D,
   parameter logic [4:0] FMT_PS = CODE_PS,
   parameter int         IDX_W  = 5
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_valid,
   input  logic [31:0]                  instr,
   input  logic [DP_EXP+DP_MAN:0]       src_val,
   input  logic                         sign_only,
   input  logic                         reg64,
   output logic                         out_valid,
   output logic [DP_EXP+DP_MAN:0]       result,
   output logic [IDX_W-1:0]             dst_idx,
   output logic                         wr_en,
   output logic                         invalid_op,
   output logic                         rsvd_instr,
   output logic                         unpredictable
);

   localparam int SP_W  = SP_EXP + SP_MAN + 1;
   localparam int DP_W  = DP_EXP + DP_MAN + 1;
   localparam int LANES = DP_W / SP_W;

   if (DP_W != 2 * SP_W) begin : g_bad_pair
      $error("fneg_unit: double width must hold exactly two singles");
   end

   fkind_e           kind;
   logic             legal;
   logic [IDX_W-1:0] fd;

   fneg_decode #(
      .FMT_S (FMT_S),
      .FMT_D (FMT_D),
      .FMT_PS(FMT_PS),
      .IDX_W (IDX_W)
   ) u_dec (
      .instr(instr),
      .kind (kind),
      .legal(legal),
      .fd   (fd)
   );

   logic [LANES-1:0][SP_W-1:0] sp_neg;
   logic [LANES-1:0]           sp_nan;

   for (genvar g = 0; g < LANES; g++) begin : g_sp_lane
      fneg_lane #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_lane (
         .op    (src_val[g*SP_W +: SP_W]),
         .neg   (sp_neg[g]),
         .is_nan(sp_nan[g])
      );
   end

   logic [DP_W-1:0] dp_neg;
   logic            dp_nan;

   fneg_lane #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp_lane (
      .op    (src_val),
      .neg   (dp_neg),
      .is_nan(dp_nan)
   );

   logic [DP_W-1:0] nxt_res;
   logic            nxt_nan;
   logic            undef_ps;
   logic            wr_ok;

   always_comb begin
      nxt_res = '0;
      nxt_nan = 1'b0;
      unique case (kind)
         K_SINGLE: begin
            nxt_res[SP_W-1:0] = sp_neg[0];
            nxt_nan           = sp_nan[0];
         end
         K_DOUBLE: begin
            nxt_res = dp_neg;
            nxt_nan = dp_nan;
         end
         K_PAIRED: begin
            nxt_res = sp_neg;
            nxt_nan = |sp_nan;
         end
         default: begin
            nxt_res = '0;
            nxt_nan = 1'b0;
         end
      endcase
   end

   assign undef_ps = legal && (kind == K_PAIRED) && !reg64;
   assign wr_ok    = legal && !undef_ps;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid     <= 1'b0;
         wr_en         <= 1'b0;
         invalid_op    <= 1'b0;
         rsvd_instr    <= 1'b0;
         unpredictable <= 1'b0;
         result        <= '0;
         dst_idx       <= '0;
      end else begin
         out_valid     <= in_valid;
         wr_en         <= in_valid && wr_ok;
         invalid_op    <= in_valid && wr_ok && !sign_only && nxt_nan;
         rsvd_instr    <= in_valid && !legal;
         unpredictable <= in_valid && undef_ps;
         result        <= (in_valid && wr_ok) ? nxt_res : '0;
         if (in_valid) dst_idx <= fd;
      end
   end

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> !(wr_en || invalid_op || rsvd_instr || unpredictable));
   a_r1_write_exclusive: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !(rsvd_instr || unpredictable));
   a_r4_sign_only_clean: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sign_only) |=> !invalid_op);
   a_r5_invalid_writes: assert property (@(posedge clk) disable iff (rst)
      invalid_op |-> wr_en);
   a_r2_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> result[SP_W-2:0] == $past(src_val[SP_W-2:0]));
   a_r11_zero_no_write: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !wr_en) |-> result == '0);

endmodule

// File: tb/test_fneg_unit.sv
`timescale 1ns/1ps
module test_fneg_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] instr;
   logic [63:0] src_val;
   logic        sign_only;
   logic        reg64;
   logic        out_valid;
   logic [63:0] result;
   logic [4:0]  dst_idx;
   logic        wr_en, invalid_op, rsvd_instr, unpredictable;

   int nvec  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   fneg_unit i_fneg_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
      .src_val(src_val), .sign_only(sign_only), .reg64(reg64),
      .out_valid(out_valid), .result(result), .dst_idx(dst_idx),
      .wr_en(wr_en), .invalid_op(invalid_op), .rsvd_instr(rsvd_instr),
      .unpredictable(unpredictable)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h (instr=%h src=%h so=%0b r64=%0b)",
                  tag, act, exp, instr, src_val, sign_only, reg64);
      end
   endtask

   function automatic logic [63:0] pat(int i);
      case (i)
         0:  return 64'h0000_0000_0000_0000;
         1:  return 64'h8000_0000_0000_0000;
         2:  return 64'h7FF0_0000_0000_0000;
         3:  return 64'h7FF0_0000_0000_0001;
         4:  return 64'hFFF8_0000_0000_0000;
         5:  return 64'h7F80_0000_7F80_0001;
         6:  return 64'h7FC0_0000_3F80_0000;
         7:  return 64'h3F80_0000_FF80_0000;
         8:  return 64'h0123_4567_89AB_CDEF;
         9:  return 64'hFFFF_FFFF_FFFF_FFFF;
         default: return 64'h7F80_0000_7F80_0000;
      endcase
   endfunction

   function automatic bit nan32(logic [31:0] v);
      return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
   endfunction

   function automatic bit nan64(logic [63:0] v);
      return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
   endfunction

   function automatic logic [31:0] mk(logic [5:0] opc, logic [4:0] fmt,
                                      logic [4:0] z, logic [4:0] fs,
                                      logic [4:0] fd, logic [5:0] fn);
      return {opc, fmt, z, fs, fd, fn};
   endfunction

   task automatic apply(logic [31:0] ins, logic [63:0] src, bit so, bit r64);
      bit          legal, ps, undef_ps, w;
      logic [63:0] exp_res;
      bit          exp_inv;
      string       rtag, itag;
      instr     = ins;
      src_val   = src;
      sign_only = so;
      reg64     = r64;
      in_valid  = 1'b1;
      @(negedge clk);
      ps      = (ins[25:21] == 5'b10110);
      legal   = (ins[31:26] == 6'b010001) && (ins[5:0] == 6'b000111) &&
                (ins[20:16] == 5'd0) &&
                (ins[25:21] == 5'b10000 || ins[25:21] == 5'b10001 || ps);
      undef_ps = legal && ps && !r64;
      w        = legal && !undef_ps;
      exp_res  = 64'd0;
      exp_inv  = 1'b0;
      rtag     = "R11";
      itag     = so ? "R4" : "R5";
      if (w) begin
         if (ins[25:21] == 5'b10000) begin
            exp_res = {32'd0, src[31:0] + 32'h8000_0000};
            exp_inv = nan32(src[31:0]);
            rtag    = "R3";
         end else if (ins[25:21] == 5'b10001) begin
            exp_res = src + 64'h8000_0000_0000_0000;
            exp_inv = nan64(src);
            rtag    = "R2";
         end else begin
            exp_res = {src[63:32] + 32'h8000_0000, src[31:0] + 32'h8000_0000};
            exp_inv = nan32(src[63:32]) || nan32(src[31:0]);
            rtag    = "R6";
            if (!so) itag = "R6";
         end
         if (so) exp_inv = 1'b0;
      end
      chk("R9",  64'(out_valid),     64'd1);
      chk("R1",  64'(rsvd_instr),    64'(!legal));
      chk(undef_ps ? "R7" : "R1", 64'(wr_en), 64'(w));
      chk("R7",  64'(unpredictable), 64'(undef_ps));
      chk(itag,  64'(invalid_op),    64'(exp_inv));
      chk(rtag,  result,             exp_res);
      chk("R8",  64'(dst_idx),       64'(ins[10:6]));
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; instr = '0; src_val = '0;
      sign_only = 1'b0; reg64 = 1'b1;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", 64'(out_valid), 64'd0);
      chk("R10", 64'({wr_en, invalid_op, rsvd_instr, unpredictable}), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      // R9: idle cycle
      chk("R9", 64'(out_valid), 64'd0);
      chk("R11", result, 64'd0);

      for (int f = 0; f < 32; f++)
         for (int m = 0; m < 4; m++)
            for (int p = 0; p < 11; p++)
               apply(mk(6'b010001, 5'(f), 5'd0, 5'(p + m), 5'(f + p), 6'b000111),
                     pat(p), m[0], m[1]);

      // R1: corrupted opcode, function or zero field on each legal format
      for (int k = 0; k < 3; k++) begin
         logic [4:0] fc;
         fc = (k == 0) ? 5'b10000 : (k == 1) ? 5'b10001 : 5'b10110;
         apply(mk(6'b010000, fc, 5'd0, 5'd1, 5'd2, 6'b000111), pat(8), 1'b0, 1'b1);
         apply(mk(6'b010001, fc, 5'd0, 5'd1, 5'd3, 6'b000110), pat(3), 1'b0, 1'b1);
         apply(mk(6'b010001, fc, 5'd1, 5'd1, 5'd4, 6'b000111), pat(9), 1'b0, 1'b1);
         apply(mk(6'b010001, fc, 5'd16, 5'd1, 5'd5, 6'b000111), pat(5), 1'b1, 1'b1);
      end

      // R10: reset while a valid legal input is present
      instr = mk(6'b010001, 5'b10001, 5'd0, 5'd0, 5'd7, 6'b000111);
      src_val = pat(3); sign_only = 1'b0; reg64 = 1'b1;
      in_valid = 1'b1; rst = 1'b1;
      @(negedge clk);
      chk("R10", 64'(out_valid), 64'd0);
      chk("R10", 64'({wr_en, invalid_op}), 64'd0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      // R9: no input, flags low
      chk("R9", 64'({out_valid, wr_en, invalid_op, rsvd_instr, unpredictable}), 64'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

endmodule